// File: doc/BRIEF.md
# Pairable Eight-Channel Pulse-Width Modulator

This block generates up to eight pulse-width modulated outputs from one shared clock enable. Each channel owns an 8-bit period value, an 8-bit duty value, an enable bit, an output-invert bit and an alignment bit. The alignment bit selects either a saw-tooth count (edge aligned) or an up/down count (center aligned). Period and duty written while a channel runs are held in a shadow copy. They are adopted at the next period boundary.

Any two neighbouring channels (0/1, 2/3, 4/5, 6/7) can be joined into one 16-bit channel. The even member supplies the upper byte of the period, duty and counter, and the odd member supplies the lower byte. The joined channel runs under the odd member's enable, invert and alignment bits and drives the odd member's pin. The even pin rests at its idle level. A join bit can only change while both members of its pair are stopped.

Software reaches the block through a single-cycle synchronous write port and a combinational read port.

Top module: `pwmc_top`

## Requirements
- R1: After reset every register reads 0, every counter is 0 and every pin is low.
- R2: Register map: 0x00 enable, 0x01 invert, 0x02 alignment (bit n belongs to channel n), 0x03 join (bit k belongs to pair 2k/2k+1), 0x08+n period of channel n, 0x10+n duty of channel n. Written values read back. Join bits 7:4 and every unmapped address read 0.
- R3: Alignment bit 0 (edge aligned): the count runs 0, 1, ..., P-1 and then returns to 0, one step per cycle with the clock enable high. The channel is active while count < D.
- R4: Alignment bit 1 (center aligned): the count runs 0 up to P and back down to 1, then returns to 0. A full period lasts 2·P enabled cycles, and the channel is active while count < D.
- R5: A duty of 0 keeps the pin idle. A duty ≥ period keeps the pin active for the whole period, in both alignments.
- R6: With join bit k set, the channel uses {even,odd} period, duty and counter as one 16-bit value. It runs under the odd channel's enable, invert and alignment bits and drives the odd pin. The even pin stays at its idle level.
- R7: A write to the join register leaves bit k unchanged while either channel 2k or 2k+1 is enabled. Other pairs in the same write are still updated.
- R8: Period and duty written to a running channel take effect only after the current period ends. A stopped channel adopts them at once.
- R9: Clearing a channel's enable drives its pin to the idle level in the same cycle, and the next enable starts the count at 0.
- R10: Counters advance only in cycles where the shared clock enable is high.
- R11: Invert bit 0 makes the active level high and the idle level low; invert bit 1 swaps them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared counter clock enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_out | output | 8 | Channel pins, bit n for channel n |

## Verification
A register write lands on the rising edge where reg_we is high. Read data follows reg_addr without delay. The pin is decoded directly from the counter and shadow registers, so the level for count N appears in the cycle after the N-th edge at which a running channel saw tick high. Clearing an enable changes the pin in the cycle right after the write edge. The bench drives every input at the falling edge and also samples there. It keeps tick low during register writes so that stimulus does not move the counters. It then predicts each pin from a closed-form count of ticks since enable, a modulo for edge aligned and a folded triangle for center aligned, and compares that with the pin on every sampled cycle.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_ENA       = 5'h00;
  localparam logic [ADDR_W-1:0] A_INV       = 5'h01;
  localparam logic [ADDR_W-1:0] A_ALIGN     = 5'h02;
  localparam logic [ADDR_W-1:0] A_JOIN      = 5'h03;
  localparam logic [ADDR_W-1:0] A_PER_BASE  = 5'h08;
  localparam logic [ADDR_W-1:0] A_DUTY_BASE = 5'h10;

  // channel drives its active level for this count
  function automatic logic pwmc_active(input logic [15:0] c, input logic [15:0] p,
                                       input logic [15:0] d);
    return (d != 16'd0) && ((d >= p) || (c < d));
  endfunction

  // count is at or past the last step of an edge-aligned period
  function automatic logic pwmc_top_reached(input logic [15:0] c, input logic [15:0] p);
    return ({1'b0, c} + 17'd1) >= {1'b0, p};
  endfunction

  function automatic logic pwmc_left_end(input logic [15:0] c, input logic [15:0] p);
    return (p == 16'd0) || pwmc_top_reached(c, p);
  endfunction

  // last down step of a center-aligned period
  function automatic logic pwmc_mid_end(input logic [15:0] c, input logic [15:0] p,
                                        input logic down);
    return (p == 16'd0) || (down && (c <= 16'd1));
  endfunction

endpackage

// File: rtl/pwmc_core.sv
module pwmc_core
  import pwmc_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         center,
  input  logic         inv,
  input  logic [W-1:0] per_in,
  input  logic [W-1:0] duty_in,
  output logic         pin
);

  logic [W-1:0] cnt;
  logic [W-1:0] per_q;
  logic [W-1:0] duty_q;
  logic         down;

  // named events for the checks below
  logic period_end;
  logic turn_evt;
  logic step_evt;
  logic active;

  assign period_end = center ? pwmc_mid_end(16'(cnt), 16'(per_q), down)
                             : pwmc_left_end(16'(cnt), 16'(per_q));
  assign turn_evt   = center && !down && pwmc_top_reached(16'(cnt), 16'(per_q));
  assign step_evt   = en && tick;
  assign active     = pwmc_active(16'(cnt), 16'(per_q), 16'(duty_q));
  assign pin        = (en && active) ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      down   <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (!en) begin
      cnt    <= '0;
      down   <= 1'b0;
      per_q  <= per_in;
      duty_q <= duty_in;
    end else if (tick) begin
      if (period_end) begin
        cnt    <= '0;
        down   <= 1'b0;
        per_q  <= per_in;
        duty_q <= duty_in;
      end else if (center && down) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (turn_evt) down <= 1'b1;
      end
    end
  end

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  assert_shadow_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(step_evt && period_end)) |=> ($stable(per_q) && $stable(duty_q)));

  assert_center_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && center) |-> (cnt <= per_q));

endmodule

// File: rtl/pwmc_regs.sv
module pwmc_regs
  import pwmc_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned NPAIR = NCH / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NCH-1:0]           ena,
  output logic [NCH-1:0]           inv,
  output logic [NCH-1:0]           align,
  output logic [NPAIR-1:0]         join_bits,
  output logic [NCH-1:0][7:0]      per,
  output logic [NCH-1:0][7:0]      duty
);

  logic [NPAIR-1:0] join_lock;

  for (genvar k = 0; k < NPAIR; k++) begin : g_lock
    assign join_lock[k] = ena[2*k] | ena[2*k+1];

    assert_join_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_JOIN && join_lock[k]) |=> $stable(join_bits[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena       <= '0;
      inv       <= '0;
      align     <= '0;
      join_bits <= '0;
      per       <= '0;
      duty      <= '0;
    end else if (we) begin
      if (addr == A_ENA)   ena   <= wdata[NCH-1:0];
      if (addr == A_INV)   inv   <= wdata[NCH-1:0];
      if (addr == A_ALIGN) align <= wdata[NCH-1:0];
      if (addr == A_JOIN) begin
        for (int k = 0; k < NPAIR; k++) begin
          if (!join_lock[k]) join_bits[k] <= wdata[k];
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (addr == A_PER_BASE + ADDR_W'(c))  per[c]  <= wdata;
        if (addr == A_DUTY_BASE + ADDR_W'(c)) duty[c] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == A_ENA)   rdata = 8'(ena);
    if (addr == A_INV)   rdata = 8'(inv);
    if (addr == A_ALIGN) rdata = 8'(align);
    if (addr == A_JOIN)  rdata = 8'(join_bits);
    for (int c = 0; c < NCH; c++) begin
      if (addr == A_PER_BASE + ADDR_W'(c))  rdata = per[c];
      if (addr == A_DUTY_BASE + ADDR_W'(c)) rdata = duty[c];
    end
  end

  assert_absent_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_JOIN) |-> ((rdata >> NPAIR) == 8'h00));

endmodule

// File: rtl/pwmc_pair.sv
module pwmc_pair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       join_en,
  input  logic       en_ev,
  input  logic       en_od,
  input  logic       inv_ev,
  input  logic       inv_od,
  input  logic       al_ev,
  input  logic       al_od,
  input  logic [7:0] per_ev,
  input  logic [7:0] per_od,
  input  logic [7:0] duty_ev,
  input  logic [7:0] duty_od,
  output logic       pin_ev,
  output logic       pin_od
);

  logic        ev_run;
  logic [15:0] od_per;
  logic [15:0] od_duty;

  assign ev_run  = en_ev & ~join_en;
  assign od_per  = join_en ? {per_ev, per_od}   : {8'h00, per_od};
  assign od_duty = join_en ? {duty_ev, duty_od} : {8'h00, duty_od};

  pwmc_core #(.W(8)) u_even (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (ev_run),
    .center  (al_ev),
    .inv     (inv_ev),
    .per_in  (per_ev),
    .duty_in (duty_ev),
    .pin     (pin_ev)
  );

  pwmc_core #(.W(16)) u_odd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (en_od),
    .center  (al_od),
    .inv     (inv_od),
    .per_in  (od_per),
    .duty_in (od_duty),
    .pin     (pin_od)
  );

  assert_even_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    join_en |-> (pin_ev == inv_ev));

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
  import pwmc_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned NPAIR = NCH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NCH-1:0]    pwm_out
);

  logic [NCH-1:0]      ena;
  logic [NCH-1:0]      inv;
  logic [NCH-1:0]      align;
  logic [NPAIR-1:0]    join_bits;
  logic [NCH-1:0][7:0] per;
  logic [NCH-1:0][7:0] duty;

  pwmc_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .ena       (ena),
    .inv       (inv),
    .align     (align),
    .join_bits (join_bits),
    .per       (per),
    .duty      (duty)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    pwmc_pair u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .join_en (join_bits[k]),
      .en_ev   (ena[2*k]),
      .en_od   (ena[2*k+1]),
      .inv_ev  (inv[2*k]),
      .inv_od  (inv[2*k+1]),
      .al_ev   (align[2*k]),
      .al_od   (align[2*k+1]),
      .per_ev  (per[2*k]),
      .per_od  (per[2*k+1]),
      .duty_ev (duty[2*k]),
      .duty_od (duty[2*k+1]),
      .pin_ev  (pwm_out[2*k]),
      .pin_od  (pwm_out[2*k+1])
    );
  end

endmodule

// File: tb/tb_pwmc_top.sv
module tb_pwmc_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       reg_we;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwmc_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out)
  );

  // expected pin from ticks seen since enable (closed form)
  function automatic bit exp_pin(input int n, input int per, input int duty,
                                 input bit ctr, input bit inv);
    int pos;
    int c;
    bit act;
    if (per == 0) c = 0;
    else if (!ctr) c = n % per;
    else begin
      pos = n % (2 * per);
      c = (pos <= per) ? pos : (2 * per - pos);
    end
    act = (duty != 0) && ((duty >= per) || (c < duty));
    return act ^ inv;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    tick      = 1'b0;
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_ch(input int ch, input int cyc, input int per, input int duty,
                        input bit ctr, input bit inv, input int ev, input string req,
                        inout int n);
    bit e;
    for (int i = 0; i < cyc; i++) begin
      e = exp_pin(n, per, duty, ctr, inv);
      chk(pwm_out[ch] == e, req, int'(pwm_out[ch]), int'(e));
      if (ev >= 0) chk(pwm_out[ev] == 1'b0, "R6 even pin idle", int'(pwm_out[ev]), 0);
      tick = 1'b1;
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(pwm_out == 8'h00, "R1 pins", int'(pwm_out), 0);
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      chk(d == 8'h00, "R1 reg", int'(d), 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(5'h02, 8'hA5); rd(5'h02, d); chk(d == 8'hA5, "R2 align", int'(d), 'hA5);
    wr(5'h0B, 8'h3C); rd(5'h0B, d); chk(d == 8'h3C, "R2 period3", int'(d), 'h3C);
    wr(5'h16, 8'h7E); rd(5'h16, d); chk(d == 8'h7E, "R2 duty6", int'(d), 'h7E);
    wr(5'h03, 8'hFF); rd(5'h03, d); chk(d == 8'h0F, "R2 join upper zero", int'(d), 'h0F);
    wr(5'h1F, 8'h55); rd(5'h1F, d); chk(d == 8'h00, "R2 unmapped", int'(d), 0);
    wr(5'h03, 8'h00); wr(5'h02, 8'h00); wr(5'h0B, 8'h00); wr(5'h16, 8'h00);
  endtask

  task automatic t_left();
    int n = 0;
    wr(5'h0B, 8'd7); wr(5'h13, 8'd3); wr(5'h00, 8'h08);
    run_ch(3, 20, 7, 3, 1'b0, 1'b0, -1, "R3 edge aligned", n);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_center();
    int n = 0;
    wr(5'h02, 8'h20); wr(5'h0D, 8'd5); wr(5'h15, 8'd2); wr(5'h00, 8'h20);
    run_ch(5, 25, 5, 2, 1'b1, 1'b0, -1, "R4 center aligned", n);
    wr(5'h00, 8'h00); wr(5'h02, 8'h00);
  endtask

  task automatic t_invert();
    int n = 0;
    wr(5'h01, 8'h01); wr(5'h08, 8'd6); wr(5'h10, 8'd2);
    chk(pwm_out[0] == 1'b1, "R11 idle high", int'(pwm_out[0]), 1);
    wr(5'h00, 8'h01);
    run_ch(0, 14, 6, 2, 1'b0, 1'b1, -1, "R11 inverted", n);
    wr(5'h00, 8'h00); wr(5'h01, 8'h00);
  endtask

  task automatic t_extremes();
    int n = 0;
    wr(5'h09, 8'd4); wr(5'h11, 8'd0); wr(5'h00, 8'h02);
    run_ch(1, 10, 4, 0, 1'b0, 1'b0, -1, "R5 duty zero", n);
    wr(5'h00, 8'h00); wr(5'h11, 8'd9); wr(5'h00, 8'h02); n = 0;
    run_ch(1, 10, 4, 9, 1'b0, 1'b0, -1, "R5 duty above period", n);
    wr(5'h00, 8'h00); wr(5'h02, 8'h02); wr(5'h11, 8'd4); wr(5'h00, 8'h02); n = 0;
    run_ch(1, 12, 4, 4, 1'b1, 1'b0, -1, "R5 center duty equal period", n);
    wr(5'h00, 8'h00); wr(5'h02, 8'h00);
  endtask

  task automatic t_join_wave();
    int n = 0;
    wr(5'h03, 8'h02);
    wr(5'h0A, 8'h01); wr(5'h0B, 8'h04); wr(5'h12, 8'h00); wr(5'h13, 8'h81);
    wr(5'h00, 8'h08);
    run_ch(3, 600, 16'h0104, 16'h0081, 1'b0, 1'b0, 2, "R6 joined edge aligned", n);
    wr(5'h00, 8'h00); wr(5'h03, 8'h08);
    wr(5'h0E, 8'h01); wr(5'h0F, 8'h02); wr(5'h16, 8'h01); wr(5'h17, 8'h00);
    wr(5'h02, 8'h80); wr(5'h00, 8'h80); n = 0;
    run_ch(7, 540, 16'h0102, 16'h0100, 1'b1, 1'b0, 6, "R6 joined center aligned", n);
    wr(5'h00, 8'h00); wr(5'h02, 8'h00); wr(5'h03, 8'h00);
  endtask

  task automatic t_join_lock();
    logic [7:0] d;
    wr(5'h00, 8'h02); wr(5'h03, 8'h03); rd(5'h03, d);
    chk(d == 8'h02, "R7 odd enabled blocks pair0 only", int'(d), 'h02);
    wr(5'h03, 8'h00); wr(5'h00, 8'h01); wr(5'h03, 8'h01); rd(5'h03, d);
    chk(d == 8'h00, "R7 even enabled blocks", int'(d), 0);
    wr(5'h00, 8'h00); wr(5'h03, 8'h01); rd(5'h03, d);
    chk(d == 8'h01, "R7 stopped pair accepts", int'(d), 1);
    wr(5'h00, 8'h02); wr(5'h03, 8'h00); rd(5'h03, d);
    chk(d == 8'h01, "R7 clear blocked", int'(d), 1);
    wr(5'h00, 8'h00); wr(5'h03, 8'h00); rd(5'h03, d);
    chk(d == 8'h00, "R7 clear accepted", int'(d), 0);
  endtask

  task automatic t_shadow();
    int n = 0;
    logic [7:0] d;
    wr(5'h0A, 8'd10); wr(5'h12, 8'd3); wr(5'h00, 8'h04);
    run_ch(2, 4, 10, 3, 1'b0, 1'b0, -1, "R8 before update", n);
    wr(5'h0A, 8'd6); wr(5'h12, 8'd5);
    rd(5'h0A, d); chk(d == 8'd6, "R8 new period readable", int'(d), 6);
    run_ch(2, 6, 10, 3, 1'b0, 1'b0, -1, "R8 old values hold", n);
    n = 0;
    run_ch(2, 12, 6, 5, 1'b0, 1'b0, -1, "R8 new values adopted", n);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_disable();
    int n = 0;
    wr(5'h0C, 8'd8); wr(5'h14, 8'd6); wr(5'h00, 8'h10);
    run_ch(4, 5, 8, 6, 1'b0, 1'b0, -1, "R9 running", n);
    chk(pwm_out[4] == 1'b1, "R9 active before stop", int'(pwm_out[4]), 1);
    wr(5'h00, 8'h00);
    chk(pwm_out[4] == 1'b0, "R9 idle after stop", int'(pwm_out[4]), 0);
    wr(5'h00, 8'h10); n = 0;
    run_ch(4, 10, 8, 6, 1'b0, 1'b0, -1, "R9 restart from zero", n);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_tick();
    int n = 0;
    bit e;
    wr(5'h0C, 8'd6); wr(5'h14, 8'd3); wr(5'h00, 8'h10);
    for (int i = 0; i < 36; i++) begin
      e = exp_pin(n, 6, 3, 1'b0, 1'b0);
      chk(pwm_out[4] == e, "R10 gated counting", int'(pwm_out[4]), int'(e));
      tick = (i % 3 == 0);
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
    end
    wr(5'h00, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_left();
    t_center();
    t_invert();
    t_extremes();
    t_join_wave();
    t_join_lock();
    t_shadow();
    t_disable();
    t_tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule